// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller with Open-Drain Mode

This block handles a parallel I/O port of `W` pins. Software reaches it through a small word-wide register bus, and it drives per-pin pad controls. Each pin has three pieces of state. An output latch holds the written data. A direction bit chooses input or output. A single global control bit turns on open-drain (wired-OR) drive. In that mode the high-side driver of every pin is switched off, and only the low-side driver can act. A pin that outputs a 1 therefore floats, and an external pull-up sets its level.

Open-drain drive takes effect only while the chip-mode input says the chip runs in single-chip mode. In every other mode the port drives push-pull, whatever the control bit holds.

An on-chip serial peripheral can claim any pin. While it holds a pin, the peripheral's own enable and data replace the direction bit and the latch for that pin. The latch still accepts writes. Incoming pad levels pass through a two-flop synchronizer before they can be read back.

Top module: `gpio_port_ctl`

## Requirements
- R1: After reset, the output latch, the direction register and the open-drain control bit are all 0. Every pin is then an input, and no pad driver is enabled.
- R2: A pin that no peripheral claims is an output when its direction bit is 1. In push-pull drive it sets `pad_out_o` to the latch bit, `pad_drv_hi_o` to that bit and `pad_drv_lo_o` to its inverse. `pad_drv_hi_o` and `pad_drv_lo_o` are never both 1 on the same pin.
- R3: When the control bit is 1 and `single_chip_i` is 1, every output pin keeps `pad_drv_hi_o` at 0. An output value of 0 sets `pad_drv_lo_o`. An output value of 1 leaves both drivers off. This applies to peripheral-owned pins as well.
- R4: When `single_chip_i` is 0, output pins drive push-pull whatever the control bit holds.
- R5: An input pin drives nothing. A data-register read returns its pad level after synchronization. A level present before rising edge k first shows in `rdata_o` after edge k+1, and not after edge k.
- R6: A data-register read for an output pin returns the value fed to its pad driver, not the pad level.
- R7: A write to the data register updates the latch even while the pin is an input. The value reaches the pad once the pin becomes an output.
- R8: When `periph_own_i[i]` is 1, pin i takes its output enable from `periph_oe_i[i]` and its value from `periph_do_i[i]`. The latch and the direction bit of that pin have no effect. A read returns `periph_do_i[i]` if the peripheral enables the output, and the synchronized pad level if it does not.
- R9: Register offsets on `addr_i` are as follows:
  - 0 is the data register.
  - 1 is the direction register, where 1 means output.
  - 2 holds the open-drain control bit at bit 0. Its other bits read 0.
  - 3 is unimplemented. It reads 0 and ignores writes.
  Writes take effect at the rising edge where `wr_en_i` is 1. Reads are combinational on `addr_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| single_chip_i | input | 1 | 1 when the chip runs in single-chip mode |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register offset |
| wdata_i | input | W | Write data |
| rdata_o | output | W | Read data for `addr_i` |
| pad_in_i | input | W | Sampled pad levels |
| periph_own_i | input | W | Per-pin peripheral claim |
| periph_oe_i | input | W | Peripheral output enable per pin |
| periph_do_i | input | W | Peripheral output data per pin |
| pad_drv_hi_o | output | W | High-side driver enable per pin |
| pad_drv_lo_o | output | W | Low-side driver enable per pin |
| pad_out_o | output | W | Value fed to each pad driver |

## Verification
The hardest state to reach from the ports combines several conditions on one pin:
- a peripheral has claimed it and drives it as an output;
- open-drain is active;
- the latch and direction bits disagree with the peripheral.

In that state the readback must follow the peripheral while the high-side driver stays off. The stimulus first writes a latch and direction pattern that conflicts with the peripheral. It then enables open-drain in single-chip mode. With the pad level held steady long enough to pass the synchronizer, it sweeps every claim mask against every peripheral enable pattern. A separate full sweep of direction and latch values under all four chip-mode and control-bit pairs covers the cases without a peripheral.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_DIR  = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_RSVD = 2'd3
    } sel_e;

    localparam int unsigned CTRL_OD_BIT = 0;
endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int unsigned W = 6
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         wr_en_i,
    input  logic [1:0]   addr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] lat_o,
    output logic [W-1:0] dir_o,
    output logic         od_o
);
    typedef struct packed {
        logic [W-1:0] lat;
        logic [W-1:0] dir;
        logic         od;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en_i) begin
            case (sel_e'(addr_i))
                SEL_DATA: r_d.lat = wdata_i;
                SEL_DIR:  r_d.dir = wdata_i;
                SEL_CTRL: r_d.od  = wdata_i[CTRL_OD_BIT];
                default:  r_d     = r_q;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    assign lat_o = r_q.lat;
    assign dir_o = r_q.dir;
    assign od_o  = r_q.od;
endmodule

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
    parameter int unsigned W      = 6,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] pad_i,
    output logic [W-1:0] sync_o
);
    logic [STAGES-1:0][W-1:0] st_d, st_q;

    always_comb begin
        st_d[0] = pad_i;
        for (int s = 1; s < STAGES; s++) begin
            st_d[s] = st_q[s-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign sync_o = st_q[STAGES-1];
endmodule

// File: rtl/gpio_port_drive.sv
module gpio_port_drive #(
    parameter int unsigned W = 6
) (
    input  logic [W-1:0] lat_i,
    input  logic [W-1:0] dir_i,
    input  logic         od_i,
    input  logic [W-1:0] own_i,
    input  logic [W-1:0] poe_i,
    input  logic [W-1:0] pdo_i,
    output logic [W-1:0] oe_o,
    output logic [W-1:0] val_o,
    output logic [W-1:0] hi_o,
    output logic [W-1:0] lo_o
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        // a claimed pin follows its peripheral, otherwise the registers
        assign oe_o[i]  = own_i[i] ? poe_i[i] : dir_i[i];
        assign val_o[i] = own_i[i] ? pdo_i[i] : lat_i[i];
        // open-drain removes only the high-side drive
        assign hi_o[i]  = oe_o[i] & val_o[i] & ~od_i;
        assign lo_o[i]  = oe_o[i] & ~val_o[i];
    end
endmodule

// File: rtl/gpio_port_ctl.sv
module gpio_port_ctl
    import gpio_port_pkg::*;
#(
    parameter int unsigned W         = 6,
    parameter int unsigned IN_STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         single_chip_i,
    input  logic         wr_en_i,
    input  logic [1:0]   addr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] rdata_o,
    input  logic [W-1:0] pad_in_i,
    input  logic [W-1:0] periph_own_i,
    input  logic [W-1:0] periph_oe_i,
    input  logic [W-1:0] periph_do_i,
    output logic [W-1:0] pad_drv_hi_o,
    output logic [W-1:0] pad_drv_lo_o,
    output logic [W-1:0] pad_out_o
);
    logic [W-1:0] lat_q, dir_q, pin_sync, oe, val;
    logic         od_q, od_eff;

    gpio_port_regs #(.W(W)) u_regs (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_en_i (wr_en_i),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .lat_o   (lat_q),
        .dir_o   (dir_q),
        .od_o    (od_q)
    );

    gpio_port_sync #(.W(W), .STAGES(IN_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .pad_i  (pad_in_i),
        .sync_o (pin_sync)
    );

    // the control bit counts only in single-chip mode
    assign od_eff = od_q & single_chip_i;

    gpio_port_drive #(.W(W)) u_drive (
        .lat_i (lat_q),
        .dir_i (dir_q),
        .od_i  (od_eff),
        .own_i (periph_own_i),
        .poe_i (periph_oe_i),
        .pdo_i (periph_do_i),
        .oe_o  (oe),
        .val_o (val),
        .hi_o  (pad_drv_hi_o),
        .lo_o  (pad_drv_lo_o)
    );

    assign pad_out_o = val;

    always_comb begin
        rdata_o = '0;
        case (sel_e'(addr_i))
            SEL_DATA: rdata_o = (oe & val) | (~oe & pin_sync);
            SEL_DIR:  rdata_o = dir_q;
            SEL_CTRL: rdata_o[CTRL_OD_BIT] = od_q;
            default:  rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
    parameter int unsigned W = 6
) (
    input logic         clk_i,
    input logic         rst_ni,
    input logic         single_chip_i,
    input logic         wr_en_i,
    input logic [1:0]   addr_i,
    input logic [W-1:0] wdata_i,
    input logic [W-1:0] rdata_o,
    input logic [W-1:0] pad_in_i,
    input logic [W-1:0] periph_own_i,
    input logic [W-1:0] periph_oe_i,
    input logic [W-1:0] periph_do_i,
    input logic [W-1:0] pad_drv_hi_o,
    input logic [W-1:0] pad_drv_lo_o,
    input logic [W-1:0] pad_out_o,
    input logic [W-1:0] dir_q,
    input logic         od_q
);
    logic [1:0]   since_rst;
    logic [W-1:0] oe_chk;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)              since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    assign oe_chk = (periph_own_i & periph_oe_i) | (~periph_own_i & dir_q);

    p_no_fight_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pad_drv_hi_o & pad_drv_lo_o) == '0);

    p_od_hi_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (single_chip_i && od_q) |-> (pad_drv_hi_o == '0));

    p_push_pull_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !single_chip_i |-> (pad_drv_hi_o == (oe_chk & pad_out_o)));

    p_in_sync_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (since_rst >= 2'd2 && addr_i == 2'd0) |->
            ((rdata_o & ~oe_chk) == ($past(pad_in_i, 2) & ~oe_chk)));

    p_own_data_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pad_out_o & periph_own_i) == (periph_do_i & periph_own_i));

    p_dir_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && addr_i == 2'd1) |=> (dir_q == $past(wdata_i)));

    p_rsvd_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (addr_i == 2'd3) |-> (rdata_o == '0));

    p_ctrl_upper_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (addr_i == 2'd2) |-> ((rdata_o >> 1) == '0));
endmodule

bind gpio_port_ctl gpio_port_chk #(.W(W)) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .single_chip_i (single_chip_i),
    .wr_en_i       (wr_en_i),
    .addr_i        (addr_i),
    .wdata_i       (wdata_i),
    .rdata_o       (rdata_o),
    .pad_in_i      (pad_in_i),
    .periph_own_i  (periph_own_i),
    .periph_oe_i   (periph_oe_i),
    .periph_do_i   (periph_do_i),
    .pad_drv_hi_o  (pad_drv_hi_o),
    .pad_drv_lo_o  (pad_drv_lo_o),
    .pad_out_o     (pad_out_o),
    .dir_q         (dir_q),
    .od_q          (od_q)
);

// File: tb/sim_gpio_port_ctl.sv
module sim_gpio_port_ctl;
    localparam int W = 6;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sc = 1'b0;
    logic         wr = 1'b0;
    logic [1:0]   addr = '0;
    logic [W-1:0] wdata = '0;
    logic [W-1:0] rdata;
    logic [W-1:0] pin = '0;
    logic [W-1:0] own = '0;
    logic [W-1:0] poe = '0;
    logic [W-1:0] pdo = '0;
    logic [W-1:0] hi, lo, pout;

    int total = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    gpio_port_ctl #(.W(W)) u0 (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .single_chip_i (sc),
        .wr_en_i       (wr),
        .addr_i        (addr),
        .wdata_i       (wdata),
        .rdata_o       (rdata),
        .pad_in_i      (pin),
        .periph_own_i  (own),
        .periph_oe_i   (poe),
        .periph_do_i   (pdo),
        .pad_drv_hi_o  (hi),
        .pad_drv_lo_o  (lo),
        .pad_out_o     (pout)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] want);
        total++;
        if (act !== want) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, want);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [W-1:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    // expected {hi, lo, out, data readback} from the requirements
    function automatic logic [4*W-1:0] model(input logic m_sc, input logic m_od,
        input logic [W-1:0] m_dir, input logic [W-1:0] m_lat, input logic [W-1:0] m_own,
        input logic [W-1:0] m_poe, input logic [W-1:0] m_pdo, input logic [W-1:0] m_pin);
        logic [W-1:0] e_oe, e_val, e_hi, e_lo, e_rd;
        e_oe  = (m_own & m_poe) | (~m_own & m_dir);
        e_val = (m_own & m_pdo) | (~m_own & m_lat);
        e_hi  = e_oe & e_val & {W{~(m_sc & m_od)}};
        e_lo  = e_oe & ~e_val;
        e_rd  = (e_oe & e_val) | (~e_oe & m_pin);
        return {e_hi, e_lo, e_val, e_rd};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 drive hi", {26'd0, hi}, 32'd0);
        check("R1 drive lo", {26'd0, lo}, 32'd0);
        rd_reg(2'd0, r); check("R1 data", {26'd0, r}, 32'd0);
        rd_reg(2'd1, r); check("R1 dir", {26'd0, r}, 32'd0);
        rd_reg(2'd2, r); check("R1 ctrl", {26'd0, r}, 32'd0);

        // R5 synchronizer latency
        addr = 2'd0;
        pin = 6'h2D;
        @(negedge clk); #1;
        check("R5 one edge", {26'd0, rdata}, 32'd0);
        @(negedge clk); #1;
        check("R5 two edges", {26'd0, rdata}, 32'h2D);

        // R7 latch written while input
        wr_reg(2'd0, 6'h15);
        check("R7 no drive while input", {26'd0, hi | lo}, 32'd0);
        wr_reg(2'd1, 6'h3F);
        check("R7 latch out", {26'd0, pout}, 32'h15);
        check("R7 latch hi", {26'd0, hi}, 32'h15);
        check("R7 latch lo", {26'd0, lo}, 32'h2A);

        // R9 register map
        wr_reg(2'd3, 6'h3F);
        rd_reg(2'd0, r); check("R9 data after rsvd write", {26'd0, r}, 32'h15);
        rd_reg(2'd1, r); check("R9 dir after rsvd write", {26'd0, r}, 32'h3F);
        rd_reg(2'd2, r); check("R9 ctrl after rsvd write", {26'd0, r}, 32'd0);
        rd_reg(2'd3, r); check("R9 rsvd", {26'd0, r}, 32'd0);
        wr_reg(2'd2, 6'h3F);
        rd_reg(2'd2, r); check("R9 ctrl upper bits", {26'd0, r}, 32'd1);

        // R2 R3 R4 R6: full sweep of direction and latch in each mode
        for (int m = 0; m < 4; m++) begin
            sc = m[1];
            wr_reg(2'd2, {5'd0, m[0]});
            for (int d = 0; d < 64; d++) begin
                wr_reg(2'd1, d[W-1:0]);
                for (int v = 0; v < 64; v++) begin
                    wr_reg(2'd0, v[W-1:0]);
                    addr = 2'd0; #1;
                    check(m == 3 ? "R3 open-drain" : (m == 1 ? "R4 od outside single-chip" : "R2 R6 push-pull"),
                          {8'd0, hi, lo, pout, rdata},
                          {8'd0, model(m[1], m[0], d[W-1:0], v[W-1:0], 6'h00, 6'h00, 6'h00, pin)});
                end
            end
        end

        // R8 peripheral ownership with conflicting registers
        sc = 1'b1;
        wr_reg(2'd1, 6'h0F);
        wr_reg(2'd0, 6'h33);
        for (int o = 0; o < 2; o++) begin
            wr_reg(2'd2, {5'd0, o[0]});
            addr = 2'd0;
            for (int ow = 0; ow < 64; ow++) begin
                for (int pe = 0; pe < 64; pe++) begin
                    own = ow[W-1:0];
                    poe = pe[W-1:0];
                    pdo = W'((ow * 5 + pe * 3) & 63);
                    #1;
                    check(o == 1 ? "R8 R3 owned open-drain" : "R8 owned push-pull",
                          {8'd0, hi, lo, pout, rdata},
                          {8'd0, model(1'b1, o[0], 6'h0F, 6'h33, own, poe, pdo, pin)});
                end
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule